// File: doc/BRIEF.md
# Receive Station Address Filter

This block sits in a byte-wide receive path between the frame source and the rest of the receive pipeline. Every frame opens with a six-byte destination address. The block compares that address with a stored station address. A frame whose address matches is passed on complete: every byte in its original order, with its start and end markers. A frame whose address does not match is consumed and discarded, and no output beats are produced for it. Filtering can be switched off, and the block then forwards all traffic untouched.

The station address is written through a small register port, one byte at a time. Software writes the position of the byte, then the byte value, then sets and clears a commit bit. The byte is stored only when the commit bit rises from 0 to 1. The enable bit and the address are sampled when a frame begins, so changes that arrive in the middle of a frame apply from the next frame on.

The address bytes are held in a six-entry header buffer until the decision can be made. Once a frame matches, the buffer is drained to the output, and the rest of the frame then flows straight through with ready-based backpressure.

Top module: `rx_addr_filter`

## Requirements
- R1: After the synchronous active-high reset, `out_valid` is low, `in_ready` is high, filtering is disabled and all six stored address bytes read as zero.
- R2: A write to register 0x11 with bit 0 set, when the stored commit bit was 0, copies the data register (0x0F) into the address byte selected by the index register (0x10). The stored bytes are then used by the first frame that starts after that write.
- R3: A write of 0 to bit 0 of register 0x11, or a write of 1 while that bit is already 1, stores no byte.
- R4: A commit while the index register holds a value of 6 or more changes no stored address byte.
- R5: Index 0 is compared with the first byte of the frame on the wire and index 5 with the sixth. The station address 12:34:56:78:9A:BC is therefore loaded as 0x12 at index 0 through 0xBC at index 5.
- R6: Bit 0 of register 0x0E enables filtering. While it is 0, every frame is forwarded unchanged, including frames shorter than six bytes.
- R7: While filtering is enabled, a frame is forwarded only if all six of its leading bytes equal the stored address exactly. A forwarded frame keeps every byte, its order and its `sof`/`last` flags. The all-ones address is treated like any other address.
- R8: While filtering is enabled, a frame whose `last` beat arrives before its sixth byte is dropped. A matching frame of exactly six bytes is forwarded.
- R9: A dropped frame produces no output beat. Its beats are accepted one per cycle, even while `out_ready` is low.
- R10: Changes to the enable bit or to the address during a frame do not affect that frame. They apply from the next frame.
- R11: While `out_valid` is high and `out_ready` is low, the output beat stays stable. No forwarded beat is lost or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset (0x0E enable, 0x0F data, 0x10 index, 0x11 commit) |
| reg_wdata | input | DW | Register write value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with `in_valid` |
| in_sof | input | 1 | First beat of a frame |
| in_last | input | 1 | Final beat of a frame |
| in_data | input | DW | Input byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_sof | output | 1 | First beat of a forwarded frame |
| out_last | output | 1 | Final beat of a forwarded frame |
| out_data | output | DW | Output byte |

## Verification
The properties assume a well-formed input stream: a beat held unchanged while `in_valid` is high and `in_ready` is low, and frames that run back to back, each closed by a beat with `last`. They also assume that no register write lands in the same cycle as the first beat of a frame. The bench meets these conditions by presenting beats only through a handshake task that waits for acceptance. Register writes that are meant to land inside a frame are issued several cycles after that frame's first byte has been taken. The downstream ready signal is driven in three patterns: always high, pseudo-random, and held low during a frame that is to be dropped.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HDR   = 3'd1,
    S_DRAIN = 3'd2,
    S_PASS  = 3'd3,
    S_DROP  = 3'd4
  } rxf_state_e;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs #(
  parameter int DW    = 8,
  parameter int NB    = 6,
  parameter int AW    = 8,
  parameter int A_EN  = 'h0E,
  parameter int A_DAT = 'h0F,
  parameter int A_IDX = 'h10,
  parameter int A_STB = 'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  output logic              en,
  output logic [NB*DW-1:0]  addr_flat
);
  logic [DW-1:0] dat_q;
  logic [DW-1:0] idx_q;
  logic          stb_q;
  logic          commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      dat_q <= '0;
      idx_q <= '0;
      stb_q <= 1'b0;
    end else if (wr) begin
      if (waddr == AW'(A_EN))  en    <= wdata[0];
      if (waddr == AW'(A_DAT)) dat_q <= wdata;
      if (waddr == AW'(A_IDX)) idx_q <= wdata;
      if (waddr == AW'(A_STB)) stb_q <= wdata[0];
    end
  end

  // a byte is stored only on a rising commit bit with an in-range index
  assign commit = wr && (waddr == AW'(A_STB)) && wdata[0] && !stb_q
                  && (idx_q < DW'(NB));

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)                               byte_q <= '0;
      else if (commit && idx_q == DW'(g))    byte_q <= dat_q;
    end
    assign addr_flat[g*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int DW = 8,
  parameter int NB = 6,
  localparam int CW = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  input  logic [CW-1:0]     pos,
  input  logic [DW-1:0]     data,
  input  logic [NB*DW-1:0]  addr_flat,
  output logic              hit
);
  logic [DW-1:0] snap_q [NB];
  logic          m_q;

  // running match including the byte currently presented
  assign hit = m_q && (data == snap_q[pos]);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= 1'b0;
      for (int i = 0; i < NB; i++) snap_q[i] <= '0;
    end else if (start) begin
      m_q <= (data == addr_flat[DW-1:0]);
      for (int i = 0; i < NB; i++) snap_q[i] <= addr_flat[i*DW +: DW];
    end else if (step) begin
      m_q <= hit;
    end
  end
endmodule

// File: rtl/rxf_hdr_buf.sv
module rxf_hdr_buf #(
  parameter int BW = 10,
  parameter int NB = 6,
  localparam int CW = $clog2(NB)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [CW-1:0]  wpos,
  input  logic [BW-1:0]  wdata,
  input  logic [CW-1:0]  rpos,
  output logic [BW-1:0]  rdata
);
  logic [BW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (we) mem[wpos] <= wdata;
  end

  assign rdata = mem[rpos];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NB    = 6,
  parameter int AW    = 8,
  parameter int A_EN  = 'h0E,
  parameter int A_DAT = 'h0F,
  parameter int A_IDX = 'h10,
  parameter int A_STB = 'h11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_sof,
  input  logic           in_last,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           out_sof,
  output logic           out_last,
  output logic [DW-1:0]  out_data
);
  localparam int CW = $clog2(NB);
  localparam int BW = DW + 2;

  logic              en;
  logic [NB*DW-1:0]  addr_flat;
  rxf_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic              adv, acc, emit, hit;
  logic              mt_start, mt_step, buf_we;
  logic [CW-1:0]     buf_wpos;
  logic [BW-1:0]     buf_rd;

  rxf_regs #(.DW(DW), .NB(NB), .AW(AW), .A_EN(A_EN), .A_DAT(A_DAT),
             .A_IDX(A_IDX), .A_STB(A_STB)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .waddr(reg_addr), .wdata(reg_wdata),
    .en(en), .addr_flat(addr_flat)
  );

  rxf_match #(.DW(DW), .NB(NB)) u_match (
    .clk(clk), .rst(rst), .start(mt_start), .step(mt_step), .pos(cnt_q),
    .data(in_data), .addr_flat(addr_flat), .hit(hit)
  );

  rxf_hdr_buf #(.BW(BW), .NB(NB)) u_buf (
    .clk(clk), .we(buf_we), .wpos(buf_wpos),
    .wdata({in_sof, in_last, in_data}), .rpos(cnt_q), .rdata(buf_rd)
  );

  assign adv = !out_valid || out_ready;

  always_comb begin
    unique case (st_q)
      S_IDLE:  in_ready = en ? 1'b1 : adv;
      S_HDR:   in_ready = 1'b1;
      S_DRAIN: in_ready = 1'b0;
      S_PASS:  in_ready = adv;
      S_DROP:  in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign acc      = in_valid && in_ready;
  assign mt_start = acc && (st_q == S_IDLE) && en;
  assign mt_step  = acc && (st_q == S_HDR);
  assign buf_we   = mt_start || mt_step;
  assign buf_wpos = (st_q == S_IDLE) ? '0 : cnt_q;
  assign emit     = (acc && ((st_q == S_IDLE && !en) || st_q == S_PASS))
                    || (st_q == S_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (acc) begin
          if (!en) begin
            if (!in_last) st_q <= S_PASS;
          end else if (!in_last) begin
            st_q  <= S_HDR;
            cnt_q <= CW'(1);
          end
        end
        S_HDR: if (acc) begin
          if (cnt_q == CW'(NB-1)) begin
            cnt_q <= '0;
            if (hit)          st_q <= S_DRAIN;
            else if (in_last) st_q <= S_IDLE;
            else              st_q <= S_DROP;
          end else if (in_last) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_DRAIN: if (adv) begin
          if (cnt_q == CW'(NB-1)) begin
            cnt_q <= '0;
            st_q  <= buf_rd[DW] ? S_IDLE : S_PASS;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_PASS:  if (acc && in_last) st_q <= S_IDLE;
        S_DROP:  if (acc && in_last) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= emit;
      if (emit) begin
        if (st_q == S_DRAIN) {out_sof, out_last, out_data} <= buf_rd;
        else                 {out_sof, out_last, out_data} <= {in_sof, in_last, in_data};
      end
    end
  end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NB    = 6,
  parameter int AW    = 8,
  parameter int A_STB = 'h11,
  localparam int CW = $clog2(NB)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [AW-1:0]     reg_addr,
  input logic              wbit,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic [DW-1:0]     in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sof,
  input logic              out_last,
  input logic [DW-1:0]     out_data,
  input rxf_state_e        st_q,
  input logic [CW-1:0]     hdr_cnt,
  input logic [NB*DW-1:0]  addr_flat
);
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_sof) && $stable(out_last));

  // R3
  no_commit_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == AW'(A_STB) && !wbit |=> $stable(addr_flat));

  // R9
  drop_full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == S_DROP |-> in_ready);

  // R8
  short_frame_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == S_HDR && in_valid && in_ready && in_last && hdr_cnt != CW'(NB-1)
    |=> st_q == S_IDLE);

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == S_PASS && in_valid && in_ready
    |=> out_valid && out_data == $past(in_data));
endmodule

bind rx_addr_filter rxf_chk #(.DW(DW), .NB(NB), .AW(AW), .A_STB(A_STB)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wbit(reg_wdata[0]), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_sof(out_sof), .out_last(out_last),
  .out_data(out_data), .st_q(st_q), .hdr_cnt(cnt_q), .addr_flat(addr_flat)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid, out_sof, out_last;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [9:0] exp_q[$];
  logic [7:0] fb[$];
  logic [47:0] m_addr = '0;
  logic [7:0]  m_dat = '0, m_idx = '0;
  logic        m_en = 1'b0, m_stb = 1'b0;
  logic [9:0]  got_b, exp_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_last(out_last), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // downstream ready pattern
  always begin
    @(negedge clk);
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // every clock: compare any transferred beat with the reference queue
  always begin
    @(negedge clk);
    #3;
    if (!rst && out_valid && out_ready) begin
      got_b = {out_sof, out_last, out_data};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: got beat %0h expected none", cur_req, got_b);
      end else begin
        exp_b = exp_q.pop_front();
        if (got_b !== exp_b) begin
          n_fail++;
          $display("FAIL %s: got beat %0h expected %0h", cur_req, got_b, exp_b);
        end
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    int k;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      8'h0E: m_en = d[0];
      8'h0F: m_dat = d;
      8'h10: m_idx = d;
      8'h11: begin
        k = int'(m_idx);
        if (d[0] && !m_stb && k < 6) m_addr[47-8*k -: 8] = m_dat;
        m_stb = d[0];
      end
      default: ;
    endcase
  endtask

  task automatic load_addr(input logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      reg_write(8'h10, 8'(i));
      reg_write(8'h0F, a[47-8*i -: 8]);
      reg_write(8'h11, 8'h01);
      reg_write(8'h11, 8'h00);
    end
  endtask

  task automatic mk_frame(input logic [47:0] dst, input int len);
    logic [47:0] src = 48'hCBA987654321;
    fb.delete();
    for (int i = 0; i < len; i++) begin
      if (i < 6)       fb.push_back(dst[47-8*i -: 8]);
      else if (i < 12) fb.push_back(src[47-8*(i-6) -: 8]);
      else if (i == 12) fb.push_back(8'h08);
      else if (i == 13) fb.push_back(8'h00);
      else             fb.push_back(8'(i) ^ 8'h5A);
    end
  endtask

  task automatic send_frame(input logic [47:0] dst, input int len, output int cyc);
    bit fwd, ok;
    logic [47:0] hdr = '0;
    mk_frame(dst, len);
    for (int i = 0; i < 6 && i < len; i++) hdr[47-8*i -: 8] = fb[i];
    fwd = !m_en || (len >= 6 && hdr == m_addr);
    if (fwd)
      for (int i = 0; i < len; i++)
        exp_q.push_back({(i == 0), (i == len-1), fb[i]});
    cyc = 0;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_sof = (i == 0); in_last = (i == len-1); in_data = fb[i];
      ok = 1'b0;
      while (!ok) begin
        #3 ok = in_ready;
        @(negedge clk);
        cyc++;
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((exp_q.size() != 0 || out_valid) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  localparam logic [47:0] STA = 48'h123456789ABC;

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    cur_req = "R6";
    send_frame(48'hAABBCCDDEEFF, 20, cyc);    // R6 disabled: forwarded
    send_frame(48'h010203040506, 3, cyc);     // R6 short frame forwarded
    wait_idle();
    // R1 zero address after reset, filter enabled
    cur_req = "R1";
    reg_write(8'h0E, 8'h01);
    send_frame(48'h000000000000, 8, cyc);
    wait_idle();
    reg_write(8'h0E, 8'h00);
    cur_req = "R2";
    load_addr(STA);
    reg_write(8'h0E, 8'h01);
    send_frame(STA, 60, cyc);                 // R2 R7 match forwarded
    cur_req = "R5";
    send_frame(48'hBC9A78563412, 30, cyc);    // R5 reversed order dropped
    send_frame(48'h123456789ABD, 30, cyc);    // R7 last byte differs
    send_frame(48'hFFFFFFFFFFFF, 20, cyc);    // R7 broadcast dropped
    send_frame(STA, 14, cyc);                 // R5 forwarded
    wait_idle();
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    cur_req = "R8";
    send_frame(STA, 6, cyc);                  // R8 exactly six forwarded
    send_frame(STA, 5, cyc);                  // R8 dropped
    send_frame(STA, 1, cyc);                  // R8 dropped
    wait_idle();
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    // R3: clear write and repeated set store nothing
    cur_req = "R3";
    reg_write(8'h10, 8'h00);
    reg_write(8'h0F, 8'h55);
    reg_write(8'h11, 8'h00);
    send_frame(STA, 16, cyc);                 // still matches
    reg_write(8'h11, 8'h01);                  // R2 commits 0x55 at index 0
    reg_write(8'h0F, 8'h12);
    reg_write(8'h11, 8'h01);                  // R3 already set: no store
    send_frame(48'h553456789ABC, 16, cyc);    // forwarded
    send_frame(STA, 16, cyc);                 // dropped
    reg_write(8'h11, 8'h00);
    reg_write(8'h11, 8'h01);                  // stores 0x12
    reg_write(8'h11, 8'h00);
    send_frame(STA, 16, cyc);
    wait_idle();
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    // R4 out-of-range index
    cur_req = "R4";
    reg_write(8'h10, 8'h06);
    reg_write(8'h0F, 8'h00);
    reg_write(8'h11, 8'h01);
    reg_write(8'h11, 8'h00);
    reg_write(8'h10, 8'hFF);
    reg_write(8'h11, 8'h01);
    reg_write(8'h11, 8'h00);
    send_frame(STA, 20, cyc);
    wait_idle();
    check(exp_q.size() == 0 && m_addr == STA, "R4", exp_q.size(), 0);
    // R9 drop at full rate with downstream stalled
    cur_req = "R9";
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    send_frame(48'h665544332211, 40, cyc);
    check(cyc == 40, "R9", cyc, 40);
    #1 check(out_valid == 1'b0, "R9", out_valid, 0);
    rdy_mode = 0;
    wait_idle();
    // R10 enable cleared mid-frame
    cur_req = "R10";
    fork
      send_frame(STA, 30, cyc);
      begin repeat (3) @(negedge clk); reg_write(8'h0E, 8'h00); end
    join
    send_frame(48'h665544332211, 12, cyc);    // now forwarded
    wait_idle();
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    reg_write(8'h0E, 8'h01);
    fork
      send_frame(STA, 40, cyc);
      begin
        repeat (3) @(negedge clk);
        reg_write(8'h10, 8'h00);
        reg_write(8'h0F, 8'h99);
        reg_write(8'h11, 8'h01);
        reg_write(8'h11, 8'h00);
      end
    join
    send_frame(STA, 20, cyc);                 // dropped
    send_frame(48'h993456789ABC, 20, cyc);    // forwarded
    wait_idle();
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    // R11 random backpressure, mixed traffic
    cur_req = "R11";
    rdy_mode = 1;
    for (int n = 0; n < 12; n++) begin
      send_frame((n % 3 == 1) ? 48'h0A0B0C0D0E0F : 48'h993456789ABC, 6 + n * 5, cyc);
    end
    reg_write(8'h0E, 8'h00);
    for (int n = 0; n < 6; n++) send_frame(48'h0A0B0C0D0E0F, 1 + n * 7, cyc);
    wait_idle();
    check(exp_q.size() == 0, "R11", exp_q.size(), 0);
    rdy_mode = 0;
    repeat (3) @(negedge clk);
    report();
  end
endmodule